// File: doc/BRIEF.md
# Atomic Fetch-and-Add Counter Bank

This block keeps a bank of byte-addressed counters and serves atomic read-modify-write requests against them, one at a time. Each request names an operand size, a byte address inside the bank and a kind (load or store). A load hands back the value the counter held before it was touched and leaves behind that value plus a small signed increment. The increment is packed into the upper bits of the request address. A store either adds its data to the counter or overwrites it, as chosen by one control bit.

The same control bit has a second use on loads. It asks the load to hold off until an external "tag switch pending" signal drops. Storage is one 64-bit-wide synchronous RAM, so it can map onto a block RAM. Narrower counters live in byte lanes of a word, numbered big-endian. After reset the block walks the RAM and zeroes it before it accepts the first request.

Top module: `fau_bank`

## Requirements
- R1: After reset, `req_ready` stays low for exactly 2^(ADDR_W-3) cycles (256 by default) while the RAM is zeroed. After that, every counter of every size reads as zero.
- R2: A load with bit 13 clear is accepted on an edge where `req_valid` and `req_ready` are both high. `rsp_valid` is then high for one cycle after the second following edge. `rsp_data` carries the counter's previous value, zero-extended to 64 bits.
- R3: A load writes back the old value plus the sign-extended 22-bit increment held in request bits 35:14. The sum wraps modulo 2 to the power of the operand width.
- R4: A store with bit 13 = 0 adds the low operand-width bits of `req_wdata` to the counter, wrapping. A store with bit 13 = 1 replaces the counter with them. Bits 35:14 have no effect on stores.
- R5: Request bits 12:11 give the size: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits. Request bits 10:3 pick the 64-bit word. Byte offset 0 of a word is bits 63:56 (big-endian). An access changes only its own bytes.
- R6: Address bits below the access alignment are ignored. A 16-bit access clears bit 0, a 32-bit access clears bits 1:0, and a 64-bit access clears bits 2:0.
- R7: A load with bit 13 = 1 is not performed while `tag_pending` is high. Its response comes two cycles after the first edge that samples `tag_pending` low, which is one cycle later than a plain load. Loads with bit 13 = 0 ignore `tag_pending`.
- R8: Requests complete in order. `req_ready` drops for the whole operation, so an operation always sees the result of the previous one, even on the same counter.
- R9: `rsp_valid` pulses once for each accepted load and never for a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Bank idle, request taken on this edge |
| req_load | input | 1 | 1 = load (fetch-and-add), 0 = store |
| req_addr | input | 36 | Increment 35:14, flag 13, size 12:11, byte address 10:0 |
| req_wdata | input | 64 | Store operand (low bits used for narrow sizes) |
| tag_pending | input | 1 | Tag switch in progress; holds flagged loads |
| rsp_valid | output | 1 | Load response valid |
| rsp_data | output | 64 | Pre-update counter value, zero-extended |

## Verification
The test patterns are chosen so that each one exposes a different kind of fault.

- **Byte-lane patterns.** Distinct byte stores are read back as halfwords, words and doublewords. A swapped lane order or a bad lane mask shows up here.
- **Wrap-around patterns.** All-ones bytes with +1, zero with -1, and the largest positive increment separate correct wrapping from carries that leak into neighbouring lanes. They also catch a missing sign extension.
- **Misaligned addresses.** These show whether the low address bits are discarded.
- **Flagged loads.** Loads with the tag signal held high, held low, or set on an unflagged load separate the stall from the one-cycle flag penalty.
- **Back-to-back increments.** Repeated increments on one counter show whether each operation sees the previous result.

// File: rtl/fau_pkg.sv
package fau_pkg;
  localparam int unsigned WORD_W     = 64;
  localparam int unsigned WORD_BYTES = WORD_W / 8;
  localparam int unsigned OFF_W      = $clog2(WORD_BYTES);

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } fau_size_e;

  typedef enum logic [2:0] {
    ST_CLEAR,
    ST_IDLE,
    ST_HOLD,
    ST_READ,
    ST_EXEC
  } fau_state_e;
endpackage

// File: rtl/fau_ram.sv
module fau_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 64,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/fau_decode.sv
module fau_decode
  import fau_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned INC_W  = 22,
  localparam int unsigned INC_LSB = ADDR_W + 3,
  localparam int unsigned REQ_W   = INC_LSB + INC_W,
  localparam int unsigned WIDX_W  = ADDR_W - OFF_W
) (
  input  logic [REQ_W-1:0]  addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              load,
  output logic [WIDX_W-1:0] widx,
  output logic [OFF_W-1:0]  off,
  output fau_size_e         size,
  output logic              flag,
  output logic [WORD_W-1:0] operand
);
  logic [OFF_W-1:0] low_mask;
  logic [INC_W-1:0] inc;

  assign size     = fau_size_e'(addr[ADDR_W+1:ADDR_W]);
  assign flag     = addr[ADDR_W+2];
  assign widx     = addr[ADDR_W-1:OFF_W];
  assign inc      = addr[REQ_W-1:INC_LSB];
  assign low_mask = OFF_W'(((OFF_W+1)'(1) << size) - (OFF_W+1)'(1));
  assign off      = addr[OFF_W-1:0] & ~low_mask;
  assign operand  = load ? {{(WORD_W-INC_W){inc[INC_W-1]}}, inc} : wdata;
endmodule

// File: rtl/fau_lane_alu.sv
module fau_lane_alu
  import fau_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  fau_size_e         size,
  input  logic [OFF_W-1:0]  off,
  input  logic              replace,
  input  logic [WORD_W-1:0] operand,
  output logic [WORD_W-1:0] word_o,
  output logic [WORD_W-1:0] old_o
);
  logic [OFF_W:0]    nbytes;
  logic [OFF_W+3:0]  lsb;
  logic [WORD_W-1:0] wmask;
  logic [WORD_W-1:0] lane_mask;
  logic [WORD_W-1:0] result;

  always_comb begin
    nbytes    = (OFF_W+1)'(1) << size;
    lsb       = {((OFF_W+1)'(WORD_BYTES) - {1'b0, off} - nbytes), 3'b000};
    wmask     = {WORD_W{1'b1}} >> {((OFF_W+1)'(WORD_BYTES) - nbytes), 3'b000};
    lane_mask = wmask << lsb;
    old_o     = (word_i >> lsb) & wmask;
    result    = (replace ? operand : old_o + operand) & wmask;
    word_o    = (word_i & ~lane_mask) | (result << lsb);
  end

  // R5: bytes outside the selected lane pass through untouched
  always_comb begin
    p_lane_keep_r5: assert (((word_o ^ word_i) & ~lane_mask) == '0);
  end
endmodule

// File: rtl/fau_bank.sv
module fau_bank
  import fau_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned INC_W  = 22,
  localparam int unsigned REQ_W  = ADDR_W + 3 + INC_W,
  localparam int unsigned WIDX_W = ADDR_W - OFF_W,
  localparam int unsigned DEPTH  = 1 << WIDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_load,
  input  logic [REQ_W-1:0]  req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic              tag_pending,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_data
);
  fau_state_e        st_q, st_d;
  logic [WIDX_W-1:0] clr_cnt;

  logic [WIDX_W-1:0] d_widx;
  logic [OFF_W-1:0]  d_off;
  fau_size_e         d_size;
  logic              d_flag;
  logic [WORD_W-1:0] d_operand;

  logic [WIDX_W-1:0] q_widx;
  logic [OFF_W-1:0]  q_off;
  fau_size_e         q_size;
  logic              q_flag, q_load;
  logic [WORD_W-1:0] q_operand;

  logic              ram_we;
  logic [WIDX_W-1:0] ram_addr;
  logic [WORD_W-1:0] ram_wdata, ram_rdata;
  logic [WORD_W-1:0] alu_word, alu_old;
  logic              accept;

  fau_decode #(.ADDR_W(ADDR_W), .INC_W(INC_W)) u_dec (
    .addr(req_addr), .wdata(req_wdata), .load(req_load),
    .widx(d_widx), .off(d_off), .size(d_size), .flag(d_flag), .operand(d_operand)
  );

  fau_lane_alu u_alu (
    .word_i(ram_rdata), .size(q_size), .off(q_off),
    .replace(!q_load && q_flag), .operand(q_operand),
    .word_o(alu_word), .old_o(alu_old)
  );

  fau_ram #(.AW(WIDX_W), .DW(WORD_W)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .rdata(ram_rdata)
  );

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign ram_we    = (st_q == ST_CLEAR) || (st_q == ST_EXEC);
  assign ram_addr  = (st_q == ST_CLEAR) ? clr_cnt : q_widx;
  assign ram_wdata = (st_q == ST_CLEAR) ? '0 : alu_word;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_CLEAR: if (clr_cnt == WIDX_W'(DEPTH - 1)) st_d = ST_IDLE;
      ST_IDLE:  if (accept) st_d = (req_load && d_flag) ? ST_HOLD : ST_READ;
      ST_HOLD:  if (!tag_pending) st_d = ST_READ;
      ST_READ:  st_d = ST_EXEC;
      ST_EXEC:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_CLEAR;
      clr_cnt   <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      q_widx    <= '0;
      q_off     <= '0;
      q_size    <= SZ_B;
      q_flag    <= 1'b0;
      q_load    <= 1'b0;
      q_operand <= '0;
    end else begin
      st_q      <= st_d;
      rsp_valid <= (st_q == ST_EXEC) && q_load;
      if (st_q == ST_CLEAR) clr_cnt <= clr_cnt + 1'b1;
      if ((st_q == ST_EXEC) && q_load) rsp_data <= alu_old;
      if (accept) begin
        q_widx    <= d_widx;
        q_off     <= d_off;
        q_size    <= d_size;
        q_flag    <= d_flag;
        q_load    <= req_load;
        q_operand <= d_operand;
      end
    end
  end

  // R1: nothing is taken while the RAM is being zeroed
  p_clear_blocks_r1: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_CLEAR) |-> !req_ready);

  // R8: an accepted request closes the door for the next cycle
  p_serial_r8: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready);

  // R9: response is a single-cycle pulse
  p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R9: a store never produces a response
  p_store_silent_r9: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_EXEC) && !q_load) |=> !rsp_valid);

  // R7: a held load neither writes nor answers while the tag is pending
  p_tag_hold_r7: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_HOLD) && tag_pending) |=> (!ram_we && !rsp_valid));
endmodule

// File: tb/tb_fau_bank.sv
module tb_fau_bank;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_load = 1'b0;
  logic [35:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        tag_pending = 1'b0;
  logic        rsp_valid;
  logic [63:0] rsp_data;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  int exp_at = -1;
  logic [63:0] exp_data = '0;
  string cur_req = "R2";
  logic [63:0] mdl [WORDS];

  fau_bank dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_load(req_load), .req_addr(req_addr), .req_wdata(req_wdata),
    .tag_pending(tag_pending), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // per-cycle comparison against the reference expectation
  always @(negedge clk) begin
    if (!rst) begin
      vectors++;
      if (rsp_valid !== (cyc == exp_at)) begin
        fails++;
        $display("FAIL %s rsp_valid cycle %0d: got %b expected %b", cur_req, cyc, rsp_valid, cyc == exp_at);
      end else if (rsp_valid && rsp_data !== exp_data) begin
        fails++;
        $display("FAIL %s rsp_data: got %h expected %h", cur_req, rsp_data, exp_data);
      end
    end
  end

  function automatic logic [63:0] get_lane(logic [63:0] w, int off, int n);
    logic [63:0] v = '0;
    for (int i = 0; i < n; i++) v = (v << 8) | 64'(w[63-8*(off+i) -: 8]);
    return v;
  endfunction

  function automatic logic [63:0] put_lane(logic [63:0] w, int off, int n, logic [63:0] v);
    for (int i = n - 1; i >= 0; i--) begin
      w[63-8*(off+i) -: 8] = v[7:0];
      v = v >> 8;
    end
    return w;
  endfunction

  // kind: 0 store, 1 load. tag_hi drives tag_pending during the op; hold = cycles before release
  task automatic op(input bit ld, input bit flag, input int size, input int baddr,
                    input logic [21:0] inc, input logic [63:0] wd, input bit tag_hi, input int hold);
    int n, off, w, acc;
    logic [63:0] old, opnd, nv;
    n = 1 << size;
    off = ((baddr % 8) / n) * n;
    w = baddr / 8;
    @(negedge clk);
    req_valid = 1'b1;
    req_load = ld;
    req_addr = {inc, flag, 2'(size), 11'(baddr)};
    req_wdata = wd;
    tag_pending = tag_hi;
    while (!req_ready) @(negedge clk);
    acc = cyc + 1;
    old = get_lane(mdl[w], off, n);
    opnd = ld ? {{42{inc[21]}}, inc} : wd;
    nv = (!ld && flag) ? opnd : old + opnd;
    mdl[w] = put_lane(mdl[w], off, n, nv);
    if (ld) begin
      exp_data = old;
      if (!flag) exp_at = acc + 2;
      else if (!tag_hi) exp_at = acc + 3;
      else exp_at = -1;
    end
    @(negedge clk);
    req_valid = 1'b0;
    if (ld && flag && tag_hi) begin
      repeat (hold) @(negedge clk);
      exp_at = cyc + 3;
      tag_pending = 1'b0;
    end
    if (ld) while (cyc <= exp_at) @(negedge clk);
    tag_pending = 1'b0;
  endtask

  task automatic ld_chk(input string r, input int size, input int baddr, input logic [21:0] inc);
    cur_req = r;
    op(1'b1, 1'b0, size, baddr, inc, 64'h0, 1'b0, 0);
  endtask

  task automatic st(input string r, input bit repl, input int size, input int baddr, input logic [63:0] wd);
    cur_req = r;
    op(1'b0, repl, size, baddr, 22'h2AAAA, wd, 1'b0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int lows;
    for (int i = 0; i < WORDS; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: clear sequence length
    lows = 0;
    while (!req_ready) begin
      lows++;
      @(negedge clk);
    end
    vectors++;
    if (lows != WORDS) begin
      fails++;
      $display("FAIL R1 busy cycles: got %0d expected %0d", lows, WORDS);
    end
    // R1: storage reads zero in several places and sizes
    ld_chk("R1", 3, 0, 22'h0);
    ld_chk("R1", 3, 800, 22'h0);
    ld_chk("R1", 0, 2047, 22'h0);
    ld_chk("R1", 2, 1020, 22'h0);
    // R4: replace then add, junk increment field ignored
    st("R4", 1'b1, 3, 16, 64'h0123_4567_89AB_CDEF);
    ld_chk("R4", 3, 16, 22'h0);
    st("R4", 1'b0, 3, 16, 64'h1000_0000_0000_0001);
    ld_chk("R4", 3, 16, 22'h0);
    st("R4", 1'b0, 0, 20, 64'hFFFF_FFFF_FFFF_FF30);
    ld_chk("R4", 3, 16, 22'h0);
    // R5: byte lanes in big-endian order
    for (int b = 0; b < 8; b++) st("R5", 1'b1, 0, 24 + b, 64'(8'h11 * (b + 1)));
    ld_chk("R5", 3, 24, 22'h0);
    ld_chk("R5", 1, 26, 22'h0);
    ld_chk("R5", 2, 28, 22'h0);
    st("R5", 1'b1, 1, 30, 64'hBEEF);
    ld_chk("R5", 3, 24, 22'h0);
    // R3: wrap and sign extension
    st("R3", 1'b1, 0, 40, 64'hFF);
    ld_chk("R3", 0, 40, 22'h1);
    ld_chk("R3", 3, 40, 22'h0);
    ld_chk("R3", 1, 42, 22'h3FFFFF);
    ld_chk("R3", 1, 42, 22'h0);
    ld_chk("R3", 3, 48, 22'h3FFFFE);
    ld_chk("R3", 3, 48, 22'h0);
    ld_chk("R3", 2, 56, 22'h1FFFFF);
    ld_chk("R3", 2, 56, 22'h1FFFFF);
    ld_chk("R3", 3, 56, 22'h0);
    // R6: misaligned addresses snap to alignment
    st("R6", 1'b1, 2, 67, 64'hCAFE_F00D);
    ld_chk("R6", 3, 64, 22'h0);
    ld_chk("R6", 1, 71, 22'h0);
    ld_chk("R6", 3, 69, 22'h0);
    // R7: flagged loads wait for the tag switch
    cur_req = "R7";
    op(1'b1, 1'b1, 3, 80, 22'h7, 64'h0, 1'b1, 5);
    op(1'b1, 1'b1, 3, 80, 22'h7, 64'h0, 1'b1, 1);
    op(1'b1, 1'b1, 3, 80, 22'h0, 64'h0, 1'b0, 0);
    op(1'b1, 1'b0, 3, 80, 22'h2, 64'h0, 1'b1, 0);
    ld_chk("R7", 3, 80, 22'h0);
    // R8: back-to-back increments on one counter
    for (int k = 0; k < 6; k++) ld_chk("R8", 2, 100, 22'h5);
    st("R8", 1'b0, 2, 100, 64'h3);
    ld_chk("R8", 2, 100, 22'h0);
    // R9: stores stay silent (monitor checks every cycle)
    for (int k = 0; k < 4; k++) st("R9", k[0], 1, 200 + 2 * k, 64'(k * 7));
    repeat (6) @(negedge clk);
    ld_chk("R9", 3, 200, 22'h0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule